// File: doc/BRIEF.md
# Multi-Level Branch Target Predictor

This block predicts, at the moment a branch executes, where the program will go a fixed number of branches later, so that a prefetcher can fetch that code early. It keeps a direct-mapped table that is indexed and tagged by branch address. Each entry holds a small set of candidate target addresses. Each candidate carries a 2-bit saturating confidence counter. On every executed branch, the entry for that branch is read and the best-rated candidate is given out as the prefetch target.

Training uses a short shift history of recent branch addresses. When a branch executes, its observed target trains the entry of the branch that ran LOOKAHEAD-1 branches earlier. The candidate that matches the observed target gains confidence, and every other candidate of that entry loses confidence. If no candidate matches, the observed target takes a slot. Training happens on every executed branch, whether or not the fetches around it hit in the cache.

Top module: `mlbp_predictor`

## Requirements
- R1: `pred_valid` is high for exactly the one cycle after a cycle with `br_valid` high, and only when a prediction exists. `pred_target` changes only in a cycle where `pred_valid` is high.
- R2: The prediction is the target of the valid slot with the largest counter in the entry selected by `br_pc`. When counters tie, the lowest-numbered slot wins.
- R3: There is no prediction (`pred_valid` low after the event) when the selected entry is empty, holds a different tag, or has no valid slot. The set index is `br_pc[ALIGN +: log2(SETS)]` and the tag is all bits of `br_pc` above the index.
- R4: Branch event n trains the entry of the branch from event n-(LOOKAHEAD-1) with the target of event n. Events that have fewer than LOOKAHEAD-1 earlier events since reset train nothing.
- R5: When the observed target equals a valid slot's target, that slot's counter rises by one and saturates at 3. Every other valid slot's counter falls by one and saturates at 0.
- R6: When no valid slot matches, the observed target goes into the lowest-numbered invalid slot with counter 1. If every slot is valid, it replaces the slot with the lowest counter, lowest number on ties. All other valid slots fall by one.
- R7: Training an entry whose tag differs from the trained branch's tag first reclaims the entry for the new tag with all slots invalid. The entry then predicts the newly inserted target.
- R8: The lookup done for an event sees the table as it was before that same event's training write, including when both use the same entry.
- R9: Reset empties the table and the history. `pred_valid` is low during reset, and none of the first LOOKAHEAD events after reset yields a prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A branch executed this cycle |
| br_pc | input | PC_W | Address of the executed branch |
| br_target | input | PC_W | Address actually entered after the branch |
| pred_valid | output | 1 | Prediction available for the previous cycle's branch |
| pred_target | output | PC_W | Predicted prefetch target |

## Verification
The bench builds the block with LOOKAHEAD=3, which gives 8 slots per entry and a lookahead of two branches, and with only 16 sets. The small set count makes a pair of short addresses collide on one index, so tag reclaim and tag-mismatch misses both occur in a few events. Training a single branch with ten distinct targets fills all eight slots and then forces replacement by lowest counter and tie-breaking. A repeated three-branch loop drives counters into saturation, and a branch that recurs two events later makes the lookup and the training write fall on the same entry in the same cycle.

// File: rtl/mlbp_pkg.sv
package mlbp_pkg;
   localparam int CNT_W    = 2;
   localparam int CNT_INIT = 1;

   typedef logic [CNT_W-1:0] cnt_t;

   typedef enum logic {
      SEL_HIGH = 1'b0,
      SEL_LOW  = 1'b1
   } sel_mode_e;

   function automatic cnt_t cnt_up(input cnt_t c);
      return (c == '1) ? c : c + cnt_t'(1);
   endfunction

   function automatic cnt_t cnt_dn(input cnt_t c);
      return (c == '0) ? c : c - cnt_t'(1);
   endfunction
endpackage

// File: rtl/mlbp_slot_pick.sv
module mlbp_slot_pick
   import mlbp_pkg::*;
#(
   parameter int        SLOTS = 8,
   parameter sel_mode_e MODE  = SEL_HIGH,
   localparam int       SW    = $clog2(SLOTS)
) (
   input  logic [SLOTS-1:0]       slot_ok,
   input  logic [SLOTS*CNT_W-1:0] cnt_flat,
   output logic                   found,
   output logic [SW-1:0]          pick
);
   generate
      if (SLOTS < 2) begin : g_bad_slots
         $error("mlbp_slot_pick: SLOTS must be at least 2");
      end

      if (MODE == SEL_HIGH) begin : g_high
         cnt_t best;
         always_comb begin
            found = 1'b0;
            pick  = '0;
            best  = '0;
            for (int i = 0; i < SLOTS; i++) begin
               if (slot_ok[i] && (!found || cnt_flat[i*CNT_W +: CNT_W] > best)) begin
                  found = 1'b1;
                  pick  = SW'(i);
                  best  = cnt_flat[i*CNT_W +: CNT_W];
               end
            end
         end
      end else begin : g_low
         logic [CNT_W:0] best;
         logic [CNT_W:0] score;
         always_comb begin
            found = 1'b0;
            pick  = '0;
            best  = '0;
            score = '0;
            for (int i = 0; i < SLOTS; i++) begin
               score = slot_ok[i] ? {1'b1, cnt_flat[i*CNT_W +: CNT_W]} : '0;
               if (!found || score < best) begin
                  found = 1'b1;
                  pick  = SW'(i);
                  best  = score;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mlbp_history.sv
module mlbp_history #(
   parameter int  PC_W  = 32,
   parameter int  DEPTH = 2,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic [PC_W-1:0] pc_in,
   output logic [PC_W-1:0] oldest_pc,
   output logic            full
);
   logic [PC_W-1:0] stage [DEPTH];
   logic [CW-1:0]   fill;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("mlbp_history: DEPTH must be at least 1");
      end
      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage[s] <= '0;
            end else if (push) begin
               if (s == 0) stage[s] <= pc_in;
               else        stage[s] <= stage[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         fill <= '0;
      else if (push && fill != CW'(DEPTH)) fill <= fill + CW'(1);
   end

   assign full      = (fill == CW'(DEPTH));
   assign oldest_pc = stage[DEPTH-1];
endmodule

// File: rtl/mlbp_train.sv
module mlbp_train
   import mlbp_pkg::*;
#(
   parameter int  PC_W  = 32,
   parameter int  SLOTS = 8,
   localparam int SW    = $clog2(SLOTS)
) (
   input  logic                   entry_hit,
   input  logic [SLOTS-1:0]       val_in,
   input  logic [SLOTS*PC_W-1:0]  tgt_in,
   input  logic [SLOTS*CNT_W-1:0] cnt_in,
   input  logic [PC_W-1:0]        obs_tgt,
   output logic [SLOTS-1:0]       val_out,
   output logic [SLOTS*PC_W-1:0]  tgt_out,
   output logic [SLOTS*CNT_W-1:0] cnt_out
);
   logic [SLOTS-1:0] vld;
   logic [SLOTS-1:0] match;
   logic             any_match;
   logic [SW-1:0]    victim;
   logic             victim_unused_found;

   assign vld       = entry_hit ? val_in : '0;
   assign any_match = |match;

   mlbp_slot_pick #(.SLOTS(SLOTS), .MODE(SEL_LOW)) u_victim (
      .slot_ok  (vld),
      .cnt_flat (cnt_in),
      .found    (victim_unused_found),
      .pick     (victim)
   );

   generate
      for (genvar g = 0; g < SLOTS; g++) begin : g_slot
         logic            v_n;
         logic [PC_W-1:0] t_n;
         cnt_t            c_n;

         assign match[g] = vld[g] && (tgt_in[g*PC_W +: PC_W] == obs_tgt);

         always_comb begin
            v_n = vld[g];
            t_n = tgt_in[g*PC_W +: PC_W];
            c_n = cnt_in[g*CNT_W +: CNT_W];
            if (match[g]) begin
               c_n = cnt_up(c_n);
            end else if (!any_match && victim == SW'(g)) begin
               v_n = 1'b1;
               t_n = obs_tgt;
               c_n = cnt_t'(CNT_INIT);
            end else if (vld[g]) begin
               c_n = cnt_dn(c_n);
            end
         end

         assign val_out[g]                  = v_n;
         assign tgt_out[g*PC_W +: PC_W]     = t_n;
         assign cnt_out[g*CNT_W +: CNT_W]   = c_n;
      end
   endgenerate
endmodule

// File: rtl/mlbp_predictor.sv
module mlbp_predictor
   import mlbp_pkg::*;
#(
   parameter int  PC_W      = 32,
   parameter int  LOOKAHEAD = 3,
   parameter int  SETS      = 64,
   parameter int  ALIGN     = 2,
   localparam int SLOTS     = 1 << LOOKAHEAD,
   localparam int SW        = $clog2(SLOTS),
   localparam int IDX_W     = $clog2(SETS),
   localparam int TAG_W     = PC_W - ALIGN - IDX_W,
   localparam int HDEPTH    = LOOKAHEAD - 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            br_valid,
   input  logic [PC_W-1:0] br_pc,
   input  logic [PC_W-1:0] br_target,
   output logic            pred_valid,
   output logic [PC_W-1:0] pred_target
);
   generate
      if (LOOKAHEAD < 2 || LOOKAHEAD > 4) begin : g_bad_lookahead
         $error("mlbp_predictor: LOOKAHEAD must lie in 2..4");
      end
      if ((1 << IDX_W) != SETS) begin : g_bad_sets
         $error("mlbp_predictor: SETS must be a power of two");
      end
      if (ALIGN < 1 || TAG_W < 1) begin : g_bad_split
         $error("mlbp_predictor: ALIGN and SETS leave no tag bits");
      end
   endgenerate

   // table storage
   logic                   t_val  [SETS];
   logic [TAG_W-1:0]       t_tag  [SETS];
   logic [SLOTS-1:0]       t_sval [SETS];
   logic [SLOTS*PC_W-1:0]  t_tgt  [SETS];
   logic [SLOTS*CNT_W-1:0] t_cnt  [SETS];

   // lookup side
   logic [IDX_W-1:0] lk_idx;
   logic [TAG_W-1:0] lk_tag;
   logic             lk_hit;
   logic             lk_found;
   logic [SW-1:0]    lk_slot;
   logic [PC_W-1:0]  lk_target;

   assign lk_idx = br_pc[ALIGN +: IDX_W];
   assign lk_tag = br_pc[PC_W-1 -: TAG_W];
   assign lk_hit = t_val[lk_idx] && (t_tag[lk_idx] == lk_tag);

   mlbp_slot_pick #(.SLOTS(SLOTS), .MODE(SEL_HIGH)) u_best (
      .slot_ok  (lk_hit ? t_sval[lk_idx] : '0),
      .cnt_flat (t_cnt[lk_idx]),
      .found    (lk_found),
      .pick     (lk_slot)
   );

   assign lk_target = t_tgt[lk_idx][lk_slot*PC_W +: PC_W];

   // training side
   logic [PC_W-1:0]        tr_pc;
   logic                   hist_full;
   logic [IDX_W-1:0]       tr_idx;
   logic [TAG_W-1:0]       tr_tag;
   logic                   tr_hit;
   logic                   tr_we;
   logic [SLOTS-1:0]       tr_sval;
   logic [SLOTS*PC_W-1:0]  tr_tgt;
   logic [SLOTS*CNT_W-1:0] tr_cnt;

   mlbp_history #(.PC_W(PC_W), .DEPTH(HDEPTH)) u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (br_valid),
      .pc_in     (br_pc),
      .oldest_pc (tr_pc),
      .full      (hist_full)
   );

   assign tr_idx = tr_pc[ALIGN +: IDX_W];
   assign tr_tag = tr_pc[PC_W-1 -: TAG_W];
   assign tr_hit = t_val[tr_idx] && (t_tag[tr_idx] == tr_tag);
   assign tr_we  = br_valid && hist_full;

   mlbp_train #(.PC_W(PC_W), .SLOTS(SLOTS)) u_train (
      .entry_hit (tr_hit),
      .val_in    (t_sval[tr_idx]),
      .tgt_in    (t_tgt[tr_idx]),
      .cnt_in    (t_cnt[tr_idx]),
      .obs_tgt   (br_target),
      .val_out   (tr_sval),
      .tgt_out   (tr_tgt),
      .cnt_out   (tr_cnt)
   );

   logic unused_low_bits;
   assign unused_low_bits = ^{br_pc[ALIGN-1:0], tr_pc[ALIGN-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < SETS; e++) begin
            t_val[e]  <= 1'b0;
            t_sval[e] <= '0;
         end
      end else if (tr_we) begin
         t_val[tr_idx]  <= 1'b1;
         t_sval[tr_idx] <= tr_sval;
      end
   end

   always_ff @(posedge clk) begin
      if (tr_we) begin
         t_tag[tr_idx] <= tr_tag;
         t_tgt[tr_idx] <= tr_tgt;
         t_cnt[tr_idx] <= tr_cnt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pred_valid  <= 1'b0;
         pred_target <= '0;
      end else begin
         pred_valid <= br_valid && lk_found;
         if (br_valid && lk_found) pred_target <= lk_target;
      end
   end
endmodule

// File: rtl/mlbp_predictor_chk.sv
module mlbp_predictor_chk #(
   parameter int PC_W      = 32,
   parameter int LOOKAHEAD = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            br_valid,
   input logic            pred_valid,
   input logic [PC_W-1:0] pred_target,
   input logic            tr_we
);
   logic [7:0] seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     seen <= '0;
      else if (br_valid && seen < 8'(LOOKAHEAD))      seen <= seen + 8'd1;
   end

   // R1: a prediction only follows a branch event
   p_pulse_after_branch_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pred_valid |-> $past(br_valid));

   // R1: target output holds when no prediction is shown
   p_target_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_valid |-> $stable(pred_target));

   // R4: no training before enough history exists
   p_no_early_train_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tr_we |-> (seen >= 8'(LOOKAHEAD - 1)));

   // R9: the first events after reset cannot predict
   p_cold_no_pred_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && seen < 8'(LOOKAHEAD)) |=> !pred_valid);
endmodule

bind mlbp_predictor mlbp_predictor_chk #(.PC_W(PC_W), .LOOKAHEAD(LOOKAHEAD)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .br_valid    (br_valid),
   .pred_valid  (pred_valid),
   .pred_target (pred_target),
   .tr_we       (tr_we)
);

// File: tb/mlbp_predictor_test.sv
module mlbp_predictor_test;
   localparam int PC_W  = 32;
   localparam int K     = 3;
   localparam int SETS  = 16;
   localparam int SLOTS = 8;
   localparam int IW    = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            br_valid = 1'b0;
   logic [PC_W-1:0] br_pc = '0;
   logic [PC_W-1:0] br_target = '0;
   logic            pred_valid;
   logic [PC_W-1:0] pred_target;

   always #5 clk = ~clk;

   mlbp_predictor #(.PC_W(PC_W), .LOOKAHEAD(K), .SETS(SETS), .ALIGN(2)) uut (
      .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_pc(br_pc),
      .br_target(br_target), .pred_valid(pred_valid), .pred_target(pred_target)
   );

   int checks = 0;
   int fails  = 0;
   bit mon_en = 1'b0;
   bit done   = 1'b0;

   typedef struct {
      bit          v;
      logic [31:0] t;
      string       req;
   } exp_item_t;

   exp_item_t sbq[$];
   exp_item_t mon_item;

   // reference model state, built from the requirements
   bit          m_val [SETS];
   logic [31:0] m_tag [SETS];
   bit          m_sv  [SETS][SLOTS];
   logic [31:0] m_tg  [SETS][SLOTS];
   int          m_cnt [SETS][SLOTS];
   logic [31:0] m_hist [K-1];
   int          m_seen;

   task automatic chk(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int e = 0; e < SETS; e++) begin
         m_val[e] = 1'b0;
         for (int s = 0; s < SLOTS; s++) begin
            m_sv[e][s] = 1'b0; m_cnt[e][s] = 0; m_tg[e][s] = '0;
         end
      end
      for (int h = 0; h < K-1; h++) m_hist[h] = '0;
      m_seen = 0;
   endtask

   task automatic model_step(input logic [31:0] pc, input logic [31:0] tgt,
                             output bit ev, output logic [31:0] et);
      int          li, ti, best, hit, vic;
      logic [31:0] lt, tt, old;
      li = int'((pc >> 2) & (SETS-1));
      lt = pc >> (2 + IW);
      ev = 1'b0; et = '0;
      // R8: lookup before this event's training
      if (m_val[li] && m_tag[li] == lt) begin
         best = -1;
         for (int s = 0; s < SLOTS; s++)
            if (m_sv[li][s] && (best < 0 || m_cnt[li][s] > m_cnt[li][best])) best = s;
         if (best >= 0) begin ev = 1'b1; et = m_tg[li][best]; end
      end
      if (m_seen >= K-1) begin
         old = m_hist[K-2];
         ti  = int'((old >> 2) & (SETS-1));
         tt  = old >> (2 + IW);
         if (!(m_val[ti] && m_tag[ti] == tt)) begin
            m_val[ti] = 1'b1; m_tag[ti] = tt;
            for (int s = 0; s < SLOTS; s++) m_sv[ti][s] = 1'b0;
         end
         hit = -1;
         for (int s = 0; s < SLOTS; s++)
            if (m_sv[ti][s] && m_tg[ti][s] == tgt) hit = s;
         if (hit >= 0) begin
            for (int s = 0; s < SLOTS; s++) begin
               if (s == hit) m_cnt[ti][s] = (m_cnt[ti][s] < 3) ? m_cnt[ti][s] + 1 : 3;
               else if (m_sv[ti][s]) m_cnt[ti][s] = (m_cnt[ti][s] > 0) ? m_cnt[ti][s] - 1 : 0;
            end
         end else begin
            vic = -1;
            for (int s = 0; s < SLOTS; s++)
               if (vic < 0 && !m_sv[ti][s]) vic = s;
            if (vic < 0) begin
               vic = 0;
               for (int s = 1; s < SLOTS; s++)
                  if (m_cnt[ti][s] < m_cnt[ti][vic]) vic = s;
            end
            for (int s = 0; s < SLOTS; s++)
               if (s != vic && m_sv[ti][s]) m_cnt[ti][s] = (m_cnt[ti][s] > 0) ? m_cnt[ti][s] - 1 : 0;
            m_sv[ti][vic] = 1'b1; m_tg[ti][vic] = tgt; m_cnt[ti][vic] = 1;
         end
      end
      for (int h = K-2; h > 0; h--) m_hist[h] = m_hist[h-1];
      m_hist[0] = pc;
      if (m_seen < K) m_seen++;
   endtask

   // driver: one branch event per call, scoreboard item pushed
   task automatic send(input logic [31:0] pc, input logic [31:0] tgt, input string req);
      bit          ev;
      logic [31:0] et;
      exp_item_t   it;
      @(negedge clk);
      br_valid = 1'b1; br_pc = pc; br_target = tgt;
      model_step(pc, tgt, ev, et);
      it.v = ev; it.t = et; it.req = req;
      sbq.push_back(it);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      br_valid = 1'b0;
      for (int i = 1; i < n; i++) @(negedge clk);
   endtask

   // monitor
   always @(posedge clk) begin
      #2;
      if (mon_en) begin
         if (sbq.size() > 0) begin
            mon_item = sbq.pop_front();
            if (mon_item.v)
               chk(pred_valid && pred_target == mon_item.t, mon_item.req,
                   {pred_valid, pred_target}, {1'b1, mon_item.t});
            else
               chk(!pred_valid, mon_item.req, {pred_valid, pred_target}, {1'b0, 32'h0});
         end else begin
            chk(!pred_valid, "R1", {pred_valid, pred_target}, {1'b0, 32'h0});
         end
      end
   end

   localparam logic [31:0] PA  = 32'h0000_1000;  // set 0
   localparam logic [31:0] PB  = 32'h0000_1104;  // set 1
   localparam logic [31:0] PC0 = 32'h0000_1208;  // set 2
   localparam logic [31:0] PD  = 32'h0000_130C;  // set 3
   localparam logic [31:0] PE  = 32'h0000_1410;  // set 4
   localparam logic [31:0] PA2 = 32'h0000_1040;  // set 0, other tag

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      chk(!pred_valid, "R9", {pred_valid, pred_target}, {1'b0, 32'h0});
      rst_n = 1'b1;
      @(negedge clk);
      mon_en = 1'b1;

      // R4 / R9: cold start, first events train nothing and predict nothing
      send(PA, 32'hA000_0000, "R4");
      send(PB, 32'hB000_0000, "R4");
      send(PC0, 32'hC000_0000, "R9");
      idle(3);

      // R2 / R5: steady loop drives counters to saturation
      for (int i = 0; i < 6; i++) begin
         send(PA, 32'hA000_0000, "R2");
         send(PB, 32'hB000_0000, "R5");
         send(PC0, 32'hC000_0000, "R2");
      end
      idle(2);

      // R6 / R5: new target for PA via PA, PD, PE
      for (int i = 0; i < 3; i++) begin
         send(PA, 32'hA000_0000, "R5");
         send(PD, 32'hD000_0000, "R6");
         send(PE, 32'hE000_0000, "R6");
         idle(1);
      end
      send(PA, 32'hA000_0000, "R5");
      idle(2);

      // R6 / R2: fill all slots of PA, then force replacement and ties
      for (int i = 0; i < 10; i++) begin
         send(PA, 32'hA000_0000, "R2");
         send(PD, 32'hD000_0000, "R6");
         send(PE, 32'h9000_0000 + 32'(i*4), "R6");
      end
      send(PA, 32'hA000_0000, "R2");
      idle(2);

      // R8: lookup and training on the same entry in one event
      for (int i = 0; i < 4; i++) begin
         send(PA, 32'h7000_0000 + 32'(i*16), "R8");
         send(PB, 32'hB000_0000, "R8");
      end
      idle(2);

      // R7 / R3: alias on set 0 reclaims the entry
      send(PA2, 32'h1111_0000, "R7");
      send(PD, 32'hD000_0000, "R7");
      send(PE, 32'h2222_0000, "R7");
      idle(1);
      send(PA2, 32'h1111_0000, "R7");
      send(PA, 32'hA000_0000, "R3");
      send(32'h0000_1F3C, 32'h3333_0000, "R3");
      idle(4);

      wait (sbq.size() == 0);
      @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule